// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a watchdog timer with a small register port. One clock drives all of it. A fixed prescaler divides that clock by 128, and each prescaler tick lowers a 12-bit down-counter by one. When the counter runs out, the block signals a fault. Software keeps the fault away by writing a restart command to the control register. The command must carry a key byte, and a command with a wrong key does nothing.

The mode register sets how the block behaves:
- the reload value and a delta threshold;
- what a fault does: pulse a full system reset, pulse a processor-only reset, or raise a level interrupt;
- whether counting pauses while an idle input or a debug-halt input is high;
- a disable bit.

The mode register takes only the first write after reset. After that write it is locked, so a watchdog that has been disabled stays disabled until the next reset.

Out of reset the block is counting, with a full-system-reset action. A restart that arrives while the counter is still above the delta value is an early restart. It counts as an error fault and takes the same action as an underflow. Reading the status register returns the underflow and error flags, then clears both flags and the interrupt.

Top module: `wdt_core`

## Requirements
- R1: After reset all three fault outputs are low and the status register reads zero. The mode register reads back its reset value: reload = RST_RELOAD, delta = 4095, full-reset action on, everything else off. Counting is already running, so without any access a system reset pulse appears RST_RELOAD*128 cycles after reset.
- R2: The mode register sits at address 1. Its fields are: reload in bits [11:0], interrupt enable in bit 12, reset enable in bit 13, processor-only in bit 14, disable in bit 15, delta in bits [27:16], idle pause in bit 28 and debug pause in bit 29. An accepted mode write loads the counter. With reload R, the fault comes R*128 cycles later and sets status bit 0 (underflow).
- R3: Only the first mode write after reset is accepted. Later writes leave the mode register unchanged.
- R4: A write to address 0 with key 8'hA5 in bits [31:24] and bit 0 set reloads the counter from the reload field and clears the prescaler.
- R5: A control write with any other key byte has no effect on when the next fault comes.
- R6: A fault with reset enable set and processor-only clear gives a one-cycle pulse on `sys_rst_o` only.
- R7: A fault with reset enable and processor-only both set gives a one-cycle pulse on `cpu_rst_o` only.
- R8: A fault with interrupt enable set drives `irq_o` high and keeps it high. A read of address 2 returns the status, with bit 0 for underflow and bit 1 for error, then clears both bits and `irq_o`.
- R9: While the disable bit is set, no fault is ever signalled.
- R10: With the idle pause bit set, the counter and prescaler hold while `idle_i` is high.
- R11: With the debug pause bit set, the counter and prescaler hold while `dbg_halt_i` is high.
- R12: A valid restart while the counter is above the delta value sets status bit 1 (error) and applies the configured fault action one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; it is also the slow counting clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register address: 0 control, 1 mode, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| idle_i | input | 1 | Idle indication used to pause counting |
| dbg_halt_i | input | 1 | Debug halt indication used to pause counting |
| sys_rst_o | output | 1 | Full system reset request, one-cycle pulse |
| cpu_rst_o | output | 1 | Processor-only reset request, one-cycle pulse |
| irq_o | output | 1 | Fault interrupt, held until the status is read |

## Verification
A table drives four mode words, each after its own reset:
- full reset with reload 3;
- processor-only reset with reload 2;
- interrupt with reload 4;
- an early restart against a small delta.

These four cases separate the three fault actions from each other, and they separate an underflow from an error. Each case checks that the fault does not come just before R*128 cycles and does come just after.

Directed tests then cover the following:
- a wrong key against a correct key, where only the correct key moves the fault later;
- a disable write followed by an attempt to re-enable;
- the idle and debug pause inputs held high longer than a full timeout and then released;
- the reset-time timeout with no bus access at all.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW = 32;
  localparam int RW = 12;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_MODE = 1;
  localparam int ADDR_STAT = 2;

  localparam int       KEY_MSB     = 31;
  localparam int       KEY_W       = 8;
  localparam bit [7:0] RESTART_KEY = 8'hA5;
  localparam int       RESTART_BIT = 0;

  typedef struct packed {
    logic          dbg_pause;
    logic          idle_pause;
    logic [RW-1:0] delta;
    logic          dis;
    logic          cpu_only;
    logic          rst_en;
    logic          irq_en;
    logic [RW-1:0] reload;
  } mode_t;

  localparam int MODE_BITS = $bits(mode_t);
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || clr)
          pre_q <= '0;
        else if (run) begin
          if (pre_q == PW'(DIV - 1))
            pre_q <= '0;
          else
            pre_q <= pre_q + 1'b1;
        end
      end
      assign tick = run && (pre_q == PW'(DIV - 1));
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CW      = 12,
  parameter int RST_VAL = 4095
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] delta,
  input  logic          armed,
  output logic          uf_fault,
  output logic          err_fault,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= CW'(RST_VAL);
    else if (load)
      cnt_q <= load_val;
    else if (tick) begin
      if (cnt_q <= CW'(1))
        cnt_q <= load_val;
      else
        cnt_q <= cnt_q - 1'b1;
    end
  end

  // underflow: last count consumed; error: restart before the window opens
  assign uf_fault  = armed && tick && (cnt_q <= CW'(1));
  assign err_fault = armed && restart && (cnt_q > delta);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int AW         = 2,
  parameter int RST_RELOAD = 4095
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          uf_fault,
  input  logic          err_fault,
  output mode_t         mode_o,
  output logic          load_o,
  output logic [RW-1:0] load_val_o,
  output logic          restart_o,
  output logic          sys_rst_o,
  output logic          cpu_rst_o,
  output logic          irq_o
);
  localparam mode_t MODE_RST = '{
    dbg_pause:  1'b0,
    idle_pause: 1'b0,
    delta:      {RW{1'b1}},
    dis:        1'b0,
    cpu_only:   1'b0,
    rst_en:     1'b1,
    irq_en:     1'b0,
    reload:     RW'(RST_RELOAD)
  };

  mode_t mode_q;
  mode_t mode_new;
  logic  locked_q, uf_q, err_q, irq_q, sys_q, cpu_q;
  logic  mode_wr, ctrl_ok, stat_rd, fault;

  assign mode_new = mode_t'(bus_wdata[MODE_BITS-1:0]);
  assign mode_wr  = bus_wr && (bus_addr == AW'(ADDR_MODE)) && !locked_q;
  assign ctrl_ok  = bus_wr && (bus_addr == AW'(ADDR_CTRL))
                    && (bus_wdata[KEY_MSB -: KEY_W] == RESTART_KEY)
                    && bus_wdata[RESTART_BIT];
  assign stat_rd  = bus_rd && (bus_addr == AW'(ADDR_STAT));
  assign fault    = uf_fault || err_fault;

  assign load_o     = mode_wr || ctrl_ok;
  assign load_val_o = mode_wr ? mode_new.reload : mode_q.reload;
  assign restart_o  = ctrl_ok;
  assign mode_o     = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RST;
      locked_q <= 1'b0;
    end else if (mode_wr) begin
      mode_q   <= mode_new;
      locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uf_q  <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      sys_q <= 1'b0;
      cpu_q <= 1'b0;
    end else begin
      uf_q  <= uf_fault  ? 1'b1 : (stat_rd ? 1'b0 : uf_q);
      err_q <= err_fault ? 1'b1 : (stat_rd ? 1'b0 : err_q);
      irq_q <= (fault && mode_q.irq_en) ? 1'b1 : (stat_rd ? 1'b0 : irq_q);
      sys_q <= fault && mode_q.rst_en && !mode_q.cpu_only;
      cpu_q <= fault && mode_q.rst_en && mode_q.cpu_only;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        AW'(ADDR_MODE): bus_rdata <= DW'(mode_q);
        AW'(ADDR_STAT): bus_rdata <= DW'({err_q, uf_q});
        default:        bus_rdata <= '0;
      endcase
    end
  end

  assign sys_rst_o = sys_q;
  assign cpu_rst_o = cpu_q;
  assign irq_o     = irq_q;

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> $stable(mode_q)); // R3

  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !fault) |=> !irq_o); // R8

  AST_RST_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sys_rst_o && cpu_rst_o)); // R7
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int AW         = 2,
  parameter int PRESCALE   = 128,
  parameter int RST_RELOAD = 4095
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [AW-1:0]          bus_addr,
  input  logic [wdt_pkg::DW-1:0] bus_wdata,
  output logic [wdt_pkg::DW-1:0] bus_rdata,
  input  logic                   idle_i,
  input  logic                   dbg_halt_i,
  output logic                   sys_rst_o,
  output logic                   cpu_rst_o,
  output logic                   irq_o
);
  import wdt_pkg::*;

  mode_t         mode;
  logic          load, restart, tick, run, uf_fault, err_fault;
  logic [RW-1:0] load_val, cnt;

  assign run = !mode.dis
               && !(idle_i && mode.idle_pause)
               && !(dbg_halt_i && mode.dbg_pause);

  wdt_regfile #(.AW(AW), .RST_RELOAD(RST_RELOAD)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .uf_fault   (uf_fault),
    .err_fault  (err_fault),
    .mode_o     (mode),
    .load_o     (load),
    .load_val_o (load_val),
    .restart_o  (restart),
    .sys_rst_o  (sys_rst_o),
    .cpu_rst_o  (cpu_rst_o),
    .irq_o      (irq_o)
  );

  wdt_prescale #(.DIV(PRESCALE)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (load),
    .run  (run),
    .tick (tick)
  );

  wdt_downcount #(.CW(RW), .RST_VAL(RST_RELOAD)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_val  (load_val),
    .tick      (tick),
    .restart   (restart),
    .delta     (mode.delta),
    .armed     (!mode.dis),
    .uf_fault  (uf_fault),
    .err_fault (err_fault),
    .cnt_o     (cnt)
  );

  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode.dis && $past(mode.dis)) |-> (!sys_rst_o && !cpu_rst_o)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (idle_i && mode.idle_pause && !load) |=> $stable(cnt)); // R10

  AST_DBG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dbg_halt_i && mode.dbg_pause && !load) |=> $stable(cnt)); // R11
endmodule

// File: tb/sim_wdt_core.sv
module sim_wdt_core;
  localparam int RRL = 3;
  localparam int PS  = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        idle_i = 1'b0, dbg_halt_i = 1'b0;
  logic        sys_rst_o, cpu_rst_o, irq_o;

  always #5 clk = ~clk;

  wdt_core #(.AW(2), .PRESCALE(PS), .RST_RELOAD(RRL)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .idle_i(idle_i), .dbg_halt_i(dbg_halt_i),
    .sys_rst_o(sys_rst_o), .cpu_rst_o(cpu_rst_o), .irq_o(irq_o)
  );

  int n_sys = 0, n_cpu = 0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (sys_rst_o) n_sys++;
    if (cpu_rst_o) n_cpu++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_mode(input int rl, input int dl, input bit irq,
      input bit rsten, input bit cpu, input bit dis, input bit idl, input bit dbg);
    return {2'b00, dbg, idl, 12'(dl), dis, cpu, rsten, irq, 12'(rl)};
  endfunction

  typedef struct packed {
    logic [11:0] rl;
    logic [11:0] dl;
    logic        irq;
    logic        rsten;
    logic        cpu;
    logic        early;
    logic        e_sys;
    logic        e_cpu;
    logic        e_irq;
    logic [1:0]  e_stat;
  } vec_t;

  localparam vec_t TBL [4] = '{
    '{12'd3, 12'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01},
    '{12'd2, 12'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01},
    '{12'd4, 12'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01},
    '{12'd5, 12'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b10}
  };

  initial begin
    logic [31:0] d;
    int s0, c0;

    // R1: reset state and counting from reset
    do_reset();
    s0 = n_sys;
    chk("R1 sys_rst low", 32'(sys_rst_o), 0);
    chk("R1 cpu_rst low", 32'(cpu_rst_o), 0);
    chk("R1 irq low", 32'(irq_o), 0);
    rd(2'd2, d); chk("R1 status zero", d, 0);
    rd(2'd1, d); chk("R1 mode reset value", d, mk_mode(RRL, 4095, 0, 1, 0, 0, 0, 0));
    cyc(RRL*PS - 8);
    chk("R1 no early fault", 32'(n_sys - s0), 0);
    cyc(14);
    chk("R1 reset-time fault", 32'(n_sys - s0), 1);

    // table walk: R2 R6 R7 R8 R12
    for (int i = 0; i < 4; i++) begin
      do_reset();
      s0 = n_sys; c0 = n_cpu;
      wr(2'd1, mk_mode(TBL[i].rl, TBL[i].dl, TBL[i].irq, TBL[i].rsten, TBL[i].cpu, 0, 0, 0));
      if (TBL[i].early) begin
        wr(2'd0, 32'hA500_0001);
        cyc(3);
      end else begin
        cyc(int'(TBL[i].rl)*PS - 4);
        chk("R2 no fault before timeout", 32'(n_sys - s0 + n_cpu - c0), 0);
        cyc(10);
      end
      chk("R6 sys pulse count", 32'(n_sys - s0), 32'(TBL[i].e_sys));
      chk("R7 cpu pulse count", 32'(n_cpu - c0), 32'(TBL[i].e_cpu));
      chk("R8 irq level", 32'(irq_o), 32'(TBL[i].e_irq));
      rd(2'd2, d);
      chk("R12 R2 status flags", d, 32'(TBL[i].e_stat));
      rd(2'd2, d);
      chk("R8 status cleared by read", d, 0);
      chk("R8 irq cleared by read", 32'(irq_o), 0);
    end

    // R5: wrong key does not postpone the fault
    do_reset();
    s0 = n_sys;
    wr(2'd1, mk_mode(3, 3, 0, 1, 0, 0, 0, 0));
    cyc(200);
    wr(2'd0, 32'h5A00_0001);
    cyc(250);
    chk("R5 wrong key ignored", 32'(n_sys - s0), 1);

    // R4: correct key postpones the fault
    do_reset();
    s0 = n_sys;
    wr(2'd1, mk_mode(3, 3, 0, 1, 0, 0, 0, 0));
    cyc(200);
    wr(2'd0, 32'hA500_0001);
    cyc(250);
    chk("R4 restart postpones fault", 32'(n_sys - s0), 0);
    cyc(200);
    chk("R4 fault after restart", 32'(n_sys - s0), 1);

    // R3 R9: disable then attempted re-enable
    do_reset();
    s0 = n_sys;
    wr(2'd1, mk_mode(2, 2, 1, 1, 0, 1, 0, 0));
    wr(2'd1, mk_mode(2, 2, 1, 1, 0, 0, 0, 0));
    rd(2'd1, d);
    chk("R3 second mode write ignored", d, mk_mode(2, 2, 1, 1, 0, 1, 0, 0));
    cyc(100);
    wr(2'd0, 32'hA500_0001);
    cyc(700);
    chk("R9 no reset when disabled", 32'(n_sys - s0), 0);
    chk("R9 no irq when disabled", 32'(irq_o), 0);

    // R10: idle pause
    do_reset();
    s0 = n_sys;
    idle_i = 1'b1;
    wr(2'd1, mk_mode(2, 2, 0, 1, 0, 0, 1, 0));
    cyc(800);
    chk("R10 held while idle", 32'(n_sys - s0), 0);
    idle_i = 1'b0;
    cyc(2*PS + 10);
    chk("R10 resumes after idle", 32'(n_sys - s0), 1);

    // R11: debug pause
    do_reset();
    s0 = n_sys;
    dbg_halt_i = 1'b1;
    wr(2'd1, mk_mode(2, 2, 0, 1, 0, 0, 0, 1));
    cyc(800);
    chk("R11 held while debug halt", 32'(n_sys - s0), 0);
    dbg_halt_i = 1'b0;
    cyc(2*PS + 10);
    chk("R11 resumes after debug halt", 32'(n_sys - s0), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule